// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

A single-port synchronous memory with a pipelined control interface. On every rising clock edge the block samples two start strobes (a processor-side `start_p_n` and a controller-side `start_c_n`), an advance strobe, three chip-select inputs, a global write, a byte-write enable and one write strobe per byte lane. A start strobe loads an external address. After that, the internal counter steps through a linear four-word group that wraps around. The advance strobe either moves the counter on or holds it in place.

Writes are full width or masked per byte lane. Reads go through two register stages. The output data is driven only while output enable is low and the output register holds a fresh read. The pad driver sits outside the block, so `dq_oe` is the tri-state control for the data pins.

A burst opened by the processor strobe never writes in its first cycle. That cycle is always a read of the loaded address. A burst opened by the controller strobe can write in the same cycle as the address.

Top module: `sbs_sram`

## Requirements
- R1: The chip is selected only when `cs_a_n`=0, `cs_b_n`=0 and `cs_c`=1. A start strobe sampled low while the chip is not selected loads nothing, writes nothing and ends any open burst. Later cycles without a strobe then do nothing.
- R2: A start strobe (`start_p_n` or `start_c_n`) sampled low while selected loads `addr` as the access address of that cycle.
- R3: In the cycle where `start_p_n` is sampled low and selected, no byte is written, whatever `gw_n`, `bwe_n` and `bw_n` are. That cycle is a read.
- R4: A `start_c_n` strobe during an open burst loads the new address, and the access goes on from that address.
- R5: In a burst cycle with no strobe and `adv_n`=1, the access address equals the previous one, so a write goes to the currently loaded address.
- R6: In a burst cycle with no strobe and `adv_n`=0, the two low address bits step by one (A, A+1, A+2, A+3, A) and the upper bits stay the same.
- R7: An access writes all lanes when `gw_n`=0, or when `gw_n`=1, `bwe_n`=0 and every bit of `bw_n` is 0.
- R8: With `gw_n`=1 and `bwe_n`=0, exactly the lanes whose `bw_n` bit is 0 are written. Lane i is bits [8i+7:8i]. The other lanes keep their data.
- R9: An access that writes no lane is a read. Its data appears on `dq_o` after the second rising edge, counting the edge that sampled the address.
- R10: `dq_oe` is 0 whenever `oe_n`=1. It is 1 exactly when `oe_n`=0 and the output register holds data from a read.
- R11: After a synchronous reset (`rst_n`=0), no burst is open and `dq_oe` stays 0 until a read has moved through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | External word address |
| start_p_n | input | 1 | Processor-side start strobe, active low |
| start_c_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Advance burst counter, active low |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b_n | input | 1 | Chip select, active low |
| cs_c | input | 1 | Chip select, active high |
| gw_n | input | 1 | Global full-width write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | N_BYTES | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | N_BYTES*BYTE_W | Write data |
| dq_o | output | N_BYTES*BYTE_W | Registered read data |
| dq_oe | output | 1 | Drive enable for the data pins |

## Verification
The hardest case to reach from the ports is the layering of burst controls. A processor-started burst is suspended with `adv_n` high, then written at the held address, then advanced across the wrap point of its group, and then cut short by a controller strobe. Only a readback of each touched word shows whether each write landed where it should.

Directed sequences build exactly these chains. Random stimulus then uses a small address space and weighted strobe and select choices, so that suspends, wraps, reloads and deselects happen many times next to masked writes. A reference model inside the bench predicts every read word and every change of `dq_oe`.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int GROUP_BITS = 2;

  // Linear step within an aligned group of four words.
  function automatic logic [GROUP_BITS-1:0] group_step(input logic [GROUP_BITS-1:0] low);
    return low + GROUP_BITS'(1);
  endfunction
endpackage

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              start_p_n,
  input  logic              start_c_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_en,
  output logic              p_first,
  output logic              cont_en
);
  import sbs_pkg::*;

  logic [ADDR_W-1:0] burst_q;
  logic              open_q;
  logic              strobe, load, desel;

  assign strobe  = !start_p_n || !start_c_n;
  assign load    = sel && strobe;
  assign desel   = strobe && !sel;
  assign cont_en = open_q && !strobe;
  assign acc_en  = load || cont_en;
  assign p_first = load && !start_p_n;

  always_comb begin
    if (load)       acc_addr = addr;
    else if (adv_n) acc_addr = burst_q;
    else            acc_addr = {burst_q[ADDR_W-1:GROUP_BITS], group_step(burst_q[GROUP_BITS-1:0])};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      burst_q <= '0;
    end else begin
      if (load)       open_q <= 1'b1;
      else if (desel) open_q <= 1'b0;
      if (acc_en)     burst_q <= acc_addr;
    end
  end

  AST_DESEL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !cont_en || !(start_p_n && start_c_n)); // R1
  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_en && adv_n) |=> $stable(burst_q)); // R5
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_en && !adv_n) |=> (burst_q[ADDR_W-1:GROUP_BITS] == $past(burst_q[ADDR_W-1:GROUP_BITS]))); // R6
  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (burst_q == $past(addr))); // R2
endmodule

// File: rtl/sbs_wr_decode.sv
module sbs_wr_decode #(
  parameter int N_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_en,
  input  logic               p_first,
  input  logic               gw_n,
  input  logic               bwe_n,
  input  logic [N_BYTES-1:0] bw_n,
  output logic [N_BYTES-1:0] we_lane,
  output logic               rd_req
);
  function automatic logic [N_BYTES-1:0] lane_mask(input logic g_n, input logic b_n,
                                                   input logic [N_BYTES-1:0] s_n);
    if (!g_n) return '1;
    if (!b_n) return ~s_n;
    return '0;
  endfunction

  assign we_lane = (acc_en && !p_first) ? lane_mask(gw_n, bwe_n, bw_n) : '0;
  assign rd_req  = acc_en && (we_lane == '0);

  AST_P_FIRST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    p_first |-> (we_lane == '0) && rd_req); // R3
  AST_GLOBAL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !p_first && !gw_n) |-> (&we_lane)); // R7
  AST_WRITE_XOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> (rd_req != (we_lane != '0))); // R9
endmodule

// File: rtl/sbs_mem_pipe.sv
module sbs_mem_pipe #(
  parameter int ADDR_W  = 6,
  parameter int N_BYTES = 4,
  parameter int BYTE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [N_BYTES-1:0]        we_lane,
  input  logic                      rd_req,
  input  logic [N_BYTES*BYTE_W-1:0] din,
  input  logic                      oe_n,
  output logic [N_BYTES*BYTE_W-1:0] dq_o,
  output logic                      dq_oe
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = N_BYTES * BYTE_W;

  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] out_q;
  logic              s1_v, out_v;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];
    logic [BYTE_W-1:0] lane_rd;
    always_ff @(posedge clk) begin
      if (we_lane[g]) lane_mem[acc_addr] <= din[g*BYTE_W +: BYTE_W];
      if (rd_req)     lane_rd <= lane_mem[acc_addr];
    end
    assign rd_word[g*BYTE_W +: BYTE_W] = lane_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      out_v <= 1'b0;
      out_q <= '0;
    end else begin
      s1_v  <= rd_req;
      out_v <= s1_v;
      if (s1_v) out_q <= rd_word;
    end
  end

  assign dq_o  = out_q;
  assign dq_oe = !oe_n && out_v;

  AST_READ_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ##2 out_v); // R9
  AST_NO_READ_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lane != '0) |-> ##2 !out_v); // R9
  AST_HIZ_ON_OE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe); // R10
endmodule

// File: rtl/sbs_sram.sv
module sbs_sram #(
  parameter int ADDR_W  = 6,
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      start_p_n,
  input  logic                      start_c_n,
  input  logic                      adv_n,
  input  logic                      cs_a_n,
  input  logic                      cs_b_n,
  input  logic                      cs_c,
  input  logic                      gw_n,
  input  logic                      bwe_n,
  input  logic [N_BYTES-1:0]        bw_n,
  input  logic                      oe_n,
  input  logic [N_BYTES*BYTE_W-1:0] din,
  output logic [N_BYTES*BYTE_W-1:0] dq_o,
  output logic                      dq_oe
);
  logic              sel;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_en, p_first, cont_en, rd_req;
  logic [N_BYTES-1:0] we_lane;

  assign sel = !cs_a_n && !cs_b_n && cs_c;

  sbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .sel(sel), .start_p_n(start_p_n), .start_c_n(start_c_n),
    .adv_n(adv_n), .addr(addr), .acc_addr(acc_addr), .acc_en(acc_en),
    .p_first(p_first), .cont_en(cont_en)
  );

  sbs_wr_decode #(.N_BYTES(N_BYTES)) u_dec (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .p_first(p_first), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .we_lane(we_lane), .rd_req(rd_req)
  );

  sbs_mem_pipe #(.ADDR_W(ADDR_W), .N_BYTES(N_BYTES), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .we_lane(we_lane), .rd_req(rd_req),
    .din(din), .oe_n(oe_n), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  AST_UNSELECTED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !cont_en) |-> (we_lane == '0) && !rd_req); // R1
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !dq_oe); // R11
endmodule

// File: tb/tb_sbs_sram.sv
`timescale 1ns/1ps
module tb_sbs_sram;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic start_p_n, start_c_n, adv_n, cs_a_n, cs_b_n, cs_c, gw_n, bwe_n, oe_n;
  logic [NB-1:0] bw_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dq_o;
  logic dq_oe;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;
  string phase = "R11";

  logic [DW-1:0] mem_m [DEPTH];
  logic          m_open = 1'b0;
  logic [AW-1:0] m_burst = '0;
  logic          e_s1v = 1'b0, e_ov = 1'b0;
  logic [DW-1:0] e_s1d = '0, e_od = '0;

  always #2 clk = ~clk;

  sbs_sram #(.ADDR_W(AW), .BYTE_W(BW), .N_BYTES(NB)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .start_p_n(start_p_n), .start_c_n(start_c_n),
    .adv_n(adv_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .cs_c(cs_c), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .din(din), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  function automatic logic [AW-1:0] next_in_group(input logic [AW-1:0] a);
    logic [1:0] lo;
    lo = a[1:0] + 2'd1;
    return {a[AW-1:2], lo};
  endfunction

  function automatic logic [NB-1:0] lanes_written(input logic g, input logic b, input logic [NB-1:0] s);
    if (g == 1'b0) return {NB{1'b1}};
    if (b == 1'b0) return ~s;
    return '0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    start_p_n = 1; start_c_n = 1; adv_n = 1; cs_a_n = 0; cs_b_n = 0; cs_c = 1;
    gw_n = 1; bwe_n = 1; bw_n = '1; oe_n = 0; din = '0; addr = '0;
  endtask

  task automatic tick();
    logic sel, strobe, load, desel, cont, acc;
    logic [AW-1:0] ea;
    logic [NB-1:0] mask;
    logic nv;
    logic [DW-1:0] nd;
    @(posedge clk);
    sel = !cs_a_n && !cs_b_n && cs_c;
    strobe = !start_p_n || !start_c_n;
    load = sel && strobe;
    desel = strobe && !sel;
    cont = m_open && !strobe;
    acc = load || cont;
    if (load) ea = addr;
    else if (adv_n) ea = m_burst;
    else ea = next_in_group(m_burst);
    mask = (acc && !(load && !start_p_n)) ? lanes_written(gw_n, bwe_n, bw_n) : '0;
    nv = e_s1v; nd = e_s1d;
    e_s1v = acc && (mask == '0);
    if (e_s1v) e_s1d = mem_m[ea];
    for (int i = 0; i < NB; i++)
      if (mask[i]) mem_m[ea][i*BW +: BW] = din[i*BW +: BW];
    e_ov = nv;
    if (nv) e_od = nd;
    if (load) m_open = 1;
    else if (desel) m_open = 0;
    if (acc) m_burst = ea;
    if (!rst_n) begin
      m_open = 0; m_burst = '0; e_s1v = 0; e_ov = 0; e_od = '0;
    end
    #1;
    check(dq_oe === (!oe_n && e_ov), "R10", "dq_oe", DW'(dq_oe), DW'(!oe_n && e_ov));
    if (!oe_n && e_ov)
      check(dq_o === e_od, phase, "dq_o", dq_o, e_od);
    @(negedge clk);
  endtask

  task automatic c_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic g, input logic b, input logic [NB-1:0] s);
    idle_inputs();
    start_c_n = 0; addr = a; gw_n = g; bwe_n = b; bw_n = s; din = d; oe_n = 1;
    tick();
  endtask

  task automatic read_back(input logic [AW-1:0] a);
    idle_inputs();
    start_c_n = 0; addr = a;
    tick();
    idle_inputs();
    start_c_n = 1; cs_c = 0;
    start_p_n = 0;
    tick();
    idle_inputs();
    tick();
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_inputs();
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    phase = "R11";
    tick();
    check(dq_oe === 1'b0, "R11", "dq_oe after reset", DW'(dq_oe), '0);

    // R7: fill every word with a full-width write, alternating both forms
    phase = "R7";
    for (int a = 0; a < DEPTH; a++) begin
      if (a % 2 == 0) c_write(AW'(a), {8'(a), 8'hA5, 8'(a * 3), 8'h3C}, 0, 1, 4'b1111);
      else            c_write(AW'(a), {8'(a), 8'hA5, 8'(a * 3), 8'h3C}, 1, 0, 4'b0000);
    end
    read_back(6'd1);
    read_back(6'd2);

    // R2/R6/R9: processor-started read burst crossing the wrap point
    phase = "R6";
    idle_inputs(); start_p_n = 0; addr = 6'd14; tick();
    for (int k = 0; k < 5; k++) begin idle_inputs(); adv_n = 0; tick(); end
    idle_inputs(); cs_c = 0; start_c_n = 0; tick();
    idle_inputs(); tick(); tick();
    check(dq_oe === 1'b0, "R1", "no output after deselect", DW'(dq_oe), '0);

    // R3: processor strobe with write controls active writes nothing
    phase = "R3";
    idle_inputs(); start_p_n = 0; addr = 6'd20; gw_n = 0; din = 32'hDEAD_BEEF; tick();
    idle_inputs(); cs_c = 0; start_c_n = 0; tick();
    read_back(6'd20);

    // R5: suspend then write at held address, then advance and write
    phase = "R5";
    idle_inputs(); start_p_n = 0; addr = 6'd33; oe_n = 1; tick();
    idle_inputs(); adv_n = 1; gw_n = 0; din = 32'h1111_2222; oe_n = 1; tick();
    idle_inputs(); adv_n = 0; gw_n = 0; din = 32'h3333_4444; oe_n = 1; tick();
    idle_inputs(); cs_a_n = 1; start_c_n = 0; tick();
    read_back(6'd33);
    read_back(6'd34);

    // R4: controller strobe reloads mid-burst
    phase = "R4";
    idle_inputs(); start_p_n = 0; addr = 6'd40; tick();
    idle_inputs(); adv_n = 0; tick();
    idle_inputs(); start_c_n = 0; addr = 6'd50; gw_n = 0; din = 32'hCAFE_0050; oe_n = 1; tick();
    idle_inputs(); adv_n = 0; gw_n = 0; din = 32'hCAFE_0051; oe_n = 1; tick();
    idle_inputs(); cs_b_n = 1; start_c_n = 0; tick();
    read_back(6'd50);
    read_back(6'd51);

    // R8: masked byte write, lanes 0 and 2
    phase = "R8";
    c_write(6'd9, 32'h99887766, 1, 0, 4'b1010);
    read_back(6'd9);

    // R1: controller strobe with one select inactive writes nothing
    phase = "R1";
    idle_inputs(); cs_b_n = 1; start_c_n = 0; addr = 6'd10; gw_n = 0; din = 32'h0BAD_0BAD; tick();
    idle_inputs(); adv_n = 0; gw_n = 0; din = 32'h0BAD_0BAD; tick();
    read_back(6'd10);
    read_back(6'd11);

    // Mixed random traffic on all controls
    phase = "R9";
    for (int n = 0; n < 4000; n++) begin
      int r;
      idle_inputs();
      r = $urandom_range(0, 9);
      start_p_n = (r == 0) ? 1'b0 : 1'b1;
      start_c_n = (r == 1 || r == 2) ? 1'b0 : 1'b1;
      adv_n = $urandom_range(0, 1);
      cs_a_n = ($urandom_range(0, 7) == 0);
      cs_b_n = ($urandom_range(0, 7) == 0);
      cs_c   = ($urandom_range(0, 7) != 0);
      gw_n   = ($urandom_range(0, 5) != 0);
      bwe_n  = $urandom_range(0, 1);
      bw_n   = NB'($urandom);
      oe_n   = ($urandom_range(0, 3) == 0);
      din    = $urandom;
      addr   = AW'($urandom);
      tick();
    end
    idle_inputs(); cs_c = 0; start_c_n = 0; tick();
    for (int a = 0; a < DEPTH; a++) read_back(AW'(a));

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule